// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns one floating-point operand into an integer and reports two exception flags. The operand is either single precision (binary32) or double precision (binary64). The integer target is 32 or 64 bits wide and is either signed or unsigned. Per operation, a mode input selects between two rounding behaviours. The first rounds to the nearest integer and breaks ties toward the even value. The second truncates toward zero.

Each conversion is a one-cycle pulse on `validIn` with the operand and selectors held in that cycle. The result and the flags are registered and appear with `validOut` on the next clock edge. They then hold until the next accepted operand.

The special cases follow fixed rules:
- A signed conversion of any NaN yields all ones at the target width.
- An unsigned conversion of any negative non-zero value yields 0 and is invalid. The sign is tested before any rounding takes place.
- Infinities and out-of-range values saturate to the target's limits.

Top module: `fti_conv_top`

## Requirements
- R1: `validOut` is high exactly in the cycle after a cycle with `validIn` high and low otherwise. `result` and `status` change only on the edge that accepts an operand and otherwise hold their values.
- R2: With `srcDouble`=1 the operand is binary64 in `operand[63:0]`. With `srcDouble`=0 it is binary32 in `operand[31:0]`. `dst64`=1 selects a 64-bit target and 0 selects a 32-bit target whose value sits in `result[31:0]` with `result[63:32]`=0. `dstSigned`=1 selects a two's-complement target and 0 selects an unsigned one.
- R3: With `chopMode`=0, finite in-range values round to the nearest integer, and exact halves go to the even neighbour (2.5→2, 3.5→4, -2.5→-2).
- R4: With `chopMode`=1, finite in-range values truncate toward zero (2.75→2, -2.75→-2).
- R5: A signed conversion of any NaN, of either sign and in either mode, gives all ones at the target width and sets invalid.
- R6: An unsigned conversion of a negative non-zero input gives 0 with invalid in both modes. This includes values that would round or truncate to 0, negative denormals, -infinity and negative NaN. A positive NaN to an unsigned target also gives 0 with invalid.
- R7: Infinities and finite values whose rounded magnitude exceeds the target range saturate and set invalid. The saturation values are the target maximum for positive inputs and the signed minimum for negative inputs. This includes values that only leave the range after rounding.
- R8: `status` bit 1 is invalid and bit 5 is inexact, and bits 0, 2, 3 and 4 are always 0. Inexact is set when non-zero fraction bits are discarded and invalid is not set. The two flags are never both set.
- R9: +0 and -0 convert to 0 with no flag. Denormals convert to 0 with inexact, except negative denormals to an unsigned target, which R6 covers.
- R10: After reset, `validOut`, `result` and `status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operand and selectors valid this cycle |
| srcDouble | input | 1 | 1: binary64 operand, 0: binary32 in low half |
| dstSigned | input | 1 | 1: signed target, 0: unsigned target |
| dst64 | input | 1 | 1: 64-bit target, 0: 32-bit target |
| chopMode | input | 1 | 1: truncate toward zero, 0: nearest-even |
| operand | input | 64 | Floating-point operand |
| validOut | output | 1 | Result valid, one cycle after validIn |
| result | output | 64 | Integer result (32-bit targets zero-extended) |
| status | output | 6 | Bit 1 invalid, bit 5 inexact, others 0 |

## Verification
The main sweep walks magnitudes 0 to 9.75 in quarter steps, in both signs, through every source format, target width, signedness and mode. The quarter steps separate exact values, values below a half, exact ties and values above a half. Ties at both even and odd integers are what distinguish nearest-even from plain half-up rounding and from truncation. The negative half of the sweep shows that an unsigned target rejects values a rounding-first design would quietly turn into 0. Directed operands cover:
- quiet NaNs of both signs;
- infinities;
- the signed and unsigned 32- and 64-bit edges, including a value that overflows only after rounding;
- tiny negatives;
- denormals;
- both zeros.

// File: rtl/fti_pkg.sv
package fti_pkg;
  localparam int SP_EXP_W = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SIG_W = DP_FRAC_W + 1;
  localparam int EXP_UW = DP_EXP_W + 2;
  localparam int WIDE_W = 64;
  localparam int NARROW_W = 32;
  localparam int STAT_W = 6;
  localparam int INV_BIT = 1;
  localparam int INX_BIT = 5;

  typedef struct packed {
    logic capture;
    logic srcDouble;
    logic dstSigned;
    logic dst64;
    logic chop;
  } fti_strobe_t;

  typedef struct packed {
    logic sign;
    logic isNan;
    logic isInf;
    logic isZero;
    logic [SIG_W-1:0] sig;
    logic signed [EXP_UW-1:0] expUnb;
  } fti_info_t;
endpackage

// File: rtl/fti_unpack.sv
module fti_unpack
  import fti_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] fpIn,
  output fti_info_t             info
);
  localparam int BIAS = 2 ** (EXP_W - 1) - 1;
  localparam int PAD = DP_FRAC_W - FRAC_W;

  logic [EXP_W-1:0] expField;
  logic [FRAC_W-1:0] fracField;
  logic expAllOnes, expAllZero;
  logic [EXP_UW-1:0] effExp;

  always_comb begin
    expField = fpIn[EXP_W+FRAC_W-1:FRAC_W];
    fracField = fpIn[FRAC_W-1:0];
    expAllOnes = &expField;
    expAllZero = ~|expField;
    effExp = expAllZero ? EXP_UW'(1) : EXP_UW'(expField);
    info.sign = fpIn[EXP_W+FRAC_W];
    info.isNan = expAllOnes && (|fracField);
    info.isInf = expAllOnes && !(|fracField);
    info.isZero = expAllZero && !(|fracField);
    info.sig = SIG_W'({!expAllZero, fracField}) << PAD;
    info.expUnb = $signed(effExp - EXP_UW'(BIAS));
  end
endmodule

// File: rtl/fti_ctrl.sv
module fti_ctrl
  import fti_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic        srcDouble,
  input  logic        dstSigned,
  input  logic        dst64,
  input  logic        chopMode,
  output fti_strobe_t strb,
  output logic        validOut
);
  always_comb begin
    strb.capture = validIn;
    strb.srcDouble = srcDouble;
    strb.dstSigned = dstSigned;
    strb.dst64 = dst64;
    strb.chop = chopMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else validOut <= validIn;
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
endmodule

// File: rtl/fti_datapath.sv
module fti_datapath
  import fti_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fti_strobe_t       strb,
  input  logic [WIDE_W-1:0] operand,
  output logic [WIDE_W-1:0] resultQ,
  output logic [STAT_W-1:0] statusQ
);
  localparam int SHIFT_W = SIG_W + WIDE_W + 1;
  localparam int FRAC_LSB = SIG_W + 1;

  fti_info_t unp [2];

  for (genvar g = 0; g < 2; g++) begin : gUnp
    localparam int EW = (g == 0) ? SP_EXP_W : DP_EXP_W;
    localparam int FW = (g == 0) ? SP_FRAC_W : DP_FRAC_W;
    fti_unpack #(.EXP_W(EW), .FRAC_W(FW)) unp_i (
      .fpIn(operand[EW+FW:0]),
      .info(unp[g])
    );
  end

  fti_info_t cur;
  logic signed [EXP_UW-1:0] ePlus2;
  logic bigFlag, tinyFlag;
  logic [SHIFT_W-1:0] shifted;
  logic [WIDE_W-1:0] intPart;
  logic rndBit, stkBit, incBit, ovf;
  logic [WIDE_W:0] mag, posMax, negMax;
  logic [6:0] limW;
  logic [WIDE_W-1:0] fullMask, resD;
  logic [STAT_W-1:0] statD;

  always_comb begin
    cur = strb.srcDouble ? unp[1] : unp[0];
    ePlus2 = cur.expUnb + EXP_UW'(2);
    bigFlag = cur.expUnb > EXP_UW'(WIDE_W - 1);
    tinyFlag = cur.expUnb < -EXP_UW'(2);
    shifted = SHIFT_W'(cur.sig) << ePlus2[6:0];
    if (tinyFlag || bigFlag) begin
      intPart = '0;
      rndBit = 1'b0;
      stkBit = |cur.sig;
    end else begin
      intPart = shifted[SHIFT_W-1:FRAC_LSB];
      rndBit = shifted[FRAC_LSB-1];
      stkBit = |shifted[FRAC_LSB-2:0];
    end
    incBit = !strb.chop && rndBit && (stkBit || intPart[0]);
    mag = {1'b0, intPart} + (WIDE_W + 1)'(incBit);
    limW = strb.dst64 ? 7'(WIDE_W) : 7'(NARROW_W);
    negMax = (WIDE_W + 1)'(1) << (limW - 7'd1);
    posMax = strb.dstSigned ? negMax - (WIDE_W + 1)'(1)
                            : ((WIDE_W + 1)'(1) << limW) - (WIDE_W + 1)'(1);
    fullMask = WIDE_W'(((WIDE_W + 1)'(1) << limW) - (WIDE_W + 1)'(1));
    ovf = bigFlag || cur.isInf || (!cur.sign && mag > posMax) ||
          (cur.sign && strb.dstSigned && mag > negMax);
    statD = '0;
    if (cur.isNan) begin
      resD = strb.dstSigned ? '1 : '0;
      statD[INV_BIT] = 1'b1;
    end else if (cur.sign && !strb.dstSigned && !cur.isZero) begin
      resD = '0;
      statD[INV_BIT] = 1'b1;
    end else if (ovf) begin
      resD = (cur.sign && strb.dstSigned) ? negMax[WIDE_W-1:0] : posMax[WIDE_W-1:0];
      statD[INV_BIT] = 1'b1;
    end else begin
      resD = cur.sign ? -mag[WIDE_W-1:0] : mag[WIDE_W-1:0];
      statD[INX_BIT] = rndBit || stkBit;
    end
    resD = resD & fullMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      statusQ <= '0;
    end else if (strb.capture) begin
      resultQ <= resD;
      statusQ <= statD;
    end
  end

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusQ[INV_BIT] && statusQ[INX_BIT]) &&
    statusQ[0] == 1'b0 && statusQ[4:2] == 3'b000);
  // R2
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && !strb.dst64 |=> resultQ[WIDE_W-1:NARROW_W] == '0);
  // R6
  unsigned_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && !strb.dstSigned && cur.sign && !cur.isZero
    |=> resultQ == '0 && statusQ[INV_BIT]);
  // R5
  signed_nan_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && strb.dstSigned && cur.isNan
    |=> resultQ[NARROW_W-1:0] == '1 && statusQ[INV_BIT]);
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(resultQ) && $stable(statusQ));
endmodule

// File: rtl/fti_conv_top.sv
module fti_conv_top
  import fti_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic        srcDouble,
  input  logic        dstSigned,
  input  logic        dst64,
  input  logic        chopMode,
  input  logic [63:0] operand,
  output logic        validOut,
  output logic [63:0] result,
  output logic [5:0]  status
);
  fti_strobe_t strb;

  fti_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .srcDouble(srcDouble),
    .dstSigned(dstSigned), .dst64(dst64), .chopMode(chopMode),
    .strb(strb), .validOut(validOut)
  );

  fti_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .operand(operand),
    .resultQ(result), .statusQ(status)
  );
endmodule

// File: tb/fti_conv_top_tb_top.sv
module fti_conv_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0, srcDouble = 1'b0, dstSigned = 1'b0, dst64 = 1'b0, chopMode = 1'b0;
  logic [63:0] operand = '0;
  logic validOut;
  logic [63:0] result;
  logic [5:0] status;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  fti_conv_top dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .srcDouble(srcDouble),
    .dstSigned(dstSigned), .dst64(dst64), .chopMode(chopMode),
    .operand(operand), .validOut(validOut), .result(result), .status(status)
  );

  function automatic logic [63:0] enc(real d, bit dbl);
    logic [63:0] b = $realtobits(d);
    if (dbl) return b;
    if (b[62:0] == 63'd0) return {32'd0, b[63], 31'd0};
    return {32'd0, b[63], 8'(b[62:52] - 11'd896), b[51:29]};
  endfunction

  function automatic logic [69:0] refConv(bit neg, real mag, bit w64, bit sgn, bit chop);
    real t, fr;
    longint v;
    logic [63:0] m = w64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    if (!sgn && neg && mag != 0.0) return {6'h02, 64'd0};
    t = $floor(mag);
    fr = mag - t;
    if (!chop && (fr > 0.5 || (fr == 0.5 && (longint'(t) % 2) != 0))) t = t + 1.0;
    v = longint'(t);
    if (neg) v = -v;
    return {(fr != 0.0) ? 6'h20 : 6'h00, 64'(v) & m};
  endfunction

  task automatic conv(input logic [63:0] op, input bit dbl, input bit sgn,
                      input bit w64, input bit chop, input logic [63:0] expR,
                      input logic [5:0] expS, input string req);
    @(negedge clk);
    operand = op; srcDouble = dbl; dstSigned = sgn; dst64 = w64; chopMode = chop;
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    checks++;
    if (validOut !== 1'b1 || result !== expR || status !== expS) begin
      errors++;
      $display("FAIL %s: op=%h d%0d s%0d w%0d c%0d got v=%0b r=%h st=%h exp r=%h st=%h",
               req, op, dbl, sgn, w64, chop, validOut, result, status, expR, expS);
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [69:0] e;
    logic [63:0] heldR;
    repeat (2) @(negedge clk);
    checks++;
    // R10 reset state
    if (validOut !== 1'b0 || result !== 64'd0 || status !== 6'd0) begin
      errors++;
      $display("FAIL R10: got v=%0b r=%h st=%h exp 0", validOut, result, status);
    end
    rstN = 1'b1;

    // R2 R3 R4 R6 R8 R9 sweep: quarter steps, all pairs, both modes
    for (int k = 0; k < 10; k++)
      for (int q = 0; q < 4; q++)
        for (int n = 0; n < 2; n++)
          for (int dbl = 0; dbl < 2; dbl++)
            for (int sgn = 0; sgn < 2; sgn++)
              for (int w = 0; w < 2; w++)
                for (int c = 0; c < 2; c++) begin
                  real mag = real'(k) + real'(q) * 0.25;
                  e = refConv(n[0], mag, w[0], sgn[0], c[0]);
                  conv(enc(n[0] ? -mag : mag, dbl[0]), dbl[0], sgn[0], w[0], c[0],
                       e[63:0], e[69:64], c[0] ? "R4 sweep" : "R3 sweep");
                end

    // R6 tiny negatives, both modes and widths
    conv(64'h0000_0000_AB98_FBA8, 0, 0, 0, 0, 64'd0, 6'h02, "R6 tiny sp");
    conv(64'h0000_0000_AB98_FBA8, 0, 0, 0, 1, 64'd0, 6'h02, "R6 tiny sp chop");
    conv(64'h0000_0000_AB98_FBA8, 0, 0, 1, 0, 64'd0, 6'h02, "R6 tiny sp 64");
    conv(64'hBD73_1F75_0000_0000, 1, 0, 1, 1, 64'd0, 6'h02, "R6 tiny dp chop");
    conv(64'hBD73_1F75_0000_0000, 1, 0, 0, 0, 64'd0, 6'h02, "R6 tiny dp");
    conv(64'h0000_0000_8000_0001, 0, 0, 0, 0, 64'd0, 6'h02, "R6 neg denorm");
    conv(64'hFFF0_0000_0000_0000, 1, 0, 0, 0, 64'd0, 6'h02, "R6 -inf");
    conv(64'h0000_0000_7FC0_0000, 0, 0, 0, 0, 64'd0, 6'h02, "R6 +nan unsigned");
    // R5 NaN to signed
    conv(64'h0000_0000_7FC0_0000, 0, 1, 0, 0, 64'h0000_0000_FFFF_FFFF, 6'h02, "R5 sp nan 32");
    conv(64'h0000_0000_7FC0_0000, 0, 1, 1, 1, '1, 6'h02, "R5 sp nan 64 chop");
    conv(64'h7FF8_0000_0000_0000, 1, 1, 0, 1, 64'h0000_0000_FFFF_FFFF, 6'h02, "R5 dp nan chop");
    conv(64'hFFF8_0000_0000_0000, 1, 1, 1, 0, '1, 6'h02, "R5 dp neg nan");
    // R7 saturation
    conv(64'h0000_0000_7F80_0000, 0, 1, 0, 0, 64'h7FFF_FFFF, 6'h02, "R7 +inf s32");
    conv(64'hFFF0_0000_0000_0000, 1, 1, 1, 0, 64'h8000_0000_0000_0000, 6'h02, "R7 -inf s64");
    conv(64'h0000_0000_7F80_0000, 0, 0, 1, 1, '1, 6'h02, "R7 +inf u64");
    conv(64'h41E0_0000_0000_0000, 1, 1, 0, 0, 64'h7FFF_FFFF, 6'h02, "R7 2^31 s32");
    conv(64'h41E0_0000_0000_0000, 1, 0, 0, 0, 64'h8000_0000, 6'h00, "R2 2^31 u32");
    conv(64'hC1E0_0000_0000_0000, 1, 1, 0, 0, 64'h8000_0000, 6'h00, "R2 -2^31 s32");
    conv($realtobits(4294967295.5), 1, 0, 0, 0, 64'hFFFF_FFFF, 6'h02, "R7 round overflow");
    conv($realtobits(4294967295.5), 1, 0, 0, 1, 64'hFFFF_FFFF, 6'h20, "R4 chop no overflow");
    conv(64'h43E0_0000_0000_0000, 1, 0, 1, 0, 64'h8000_0000_0000_0000, 6'h00, "R2 2^63 u64");
    conv(64'h43E0_0000_0000_0000, 1, 1, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 6'h02, "R7 2^63 s64");
    conv($realtobits(1.0e20), 1, 1, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 6'h02, "R7 1e20 s64");
    // R9 zeros and denormals
    conv(64'h0000_0000_0000_0001, 0, 1, 0, 0, 64'd0, 6'h20, "R9 sp denorm");
    conv(64'h0000_0000_8000_0001, 0, 1, 1, 0, 64'd0, 6'h20, "R9 neg denorm signed");
    conv(64'h8000_0000_0000_0001, 1, 1, 0, 1, 64'd0, 6'h20, "R9 dp neg denorm");
    conv(64'h0000_0000_8000_0000, 0, 0, 0, 0, 64'd0, 6'h00, "R9 -0 unsigned");
    conv(64'h0000_0000_0000_0000, 1, 1, 1, 0, 64'd0, 6'h00, "R9 +0");

    // R1 hold: no capture without validIn
    conv(enc(7.0, 1'b1), 1, 1, 0, 0, 64'd7, 6'h00, "R1 load");
    heldR = result;
    @(negedge clk);
    operand = enc(3.0, 1'b1);
    @(negedge clk);
    checks++;
    if (validOut !== 1'b0 || result !== heldR || status !== 6'h00) begin
      errors++;
      $display("FAIL R1 hold: got v=%0b r=%h exp v=0 r=%h", validOut, result, heldR);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule